// File: doc/BRIEF.md
# DRAM Bank Command Sequencer

This block sits in front of a four-bank, x8 double-data-rate SDRAM and turns read and write requests into a legal stream of commands. A request arrives over a valid/ready handshake. It carries a flat word address, a direction bit and a close flag. The sequencer splits the address into column, bank and row fields and keeps the open row of every bank. It then chooses the next command: a column command on a row hit, an activate on a closed bank, or a precharge on a row miss. A second command (activate, then the column command) follows once the bank's timers allow it.

Every bank has its own down-counters. These hold back column commands after an activate, and precharges after an activate or a burst. They also hold back activates after a precharge, an auto-precharge, a refresh or the previous activate. An interval timer raises a refresh demand. The sequencer serves that demand before any new request: it closes all open banks with one precharge-all command, then issues the refresh. The read and write latencies are derived from the programmed CAS and additive latencies, and the command bus is registered.

Top module: `dram_cmd_sched`

## Requirements
- R1: The request address is split as column = addr[9:0], bank = addr[11:10], row = addr[24:12]. An activate drives the row on the address bus and the bank on the bank bus. A column command drives the column on address bits 9..0, the close flag on bit 10 and zero on bits 12..11.
- R2: Commands are encoded on chip select (always low) and active-low row strobe, column strobe and write enable. The triples (ras,cas,we) are: NOP 111, ACTIVATE 011, READ 101, WRITE 100, PRECHARGE 010, REFRESH 001. The bus shows NOP during and after reset and in every cycle with no legal command.
- R3: On a row hit the column command is chosen at once. req_ready is high in that cycle, and the command appears on the bus one clock later.
- R4: A request to a closed bank produces ACTIVATE then the column command. A request that misses the open row produces PRECHARGE with bit 10 low, then ACTIVATE, then the column command.
- R5: For the same bank, ACTIVATE to column is at least TRCD clocks, PRECHARGE to ACTIVATE at least TRP, ACTIVATE to ACTIVATE at least TRC, and ACTIVATE to PRECHARGE at least TRC-TRP. With the bank otherwise idle, the first two gaps are exact.
- R6: A column command with bit 10 high closes the bank. The next ACTIVATE to that bank comes exactly max(TRC, TRCD + column-to-precharge + TRP) clocks after the previous ACTIVATE, when the requests are back to back.
- R7: The column-to-precharge time is AL + BL/2 for a read and WL + BL/2 + TWR for a write. BL is 8 when cfg_bl8 is 1 and 4 otherwise.
- R8: rd_lat equals cfg_al + cfg_cl, and wr_lat is one clock less than rd_lat.
- R9: A refresh demand is raised every TREFI clocks. REFRESH is issued only with all banks closed. Open banks are first closed by one PRECHARGE with bit 10 high, exactly TRP clocks before the REFRESH when no other timer is running. On an idle bus, successive REFRESH commands are exactly TREFI clocks apart.
- R10: While a refresh demand is pending, no request is accepted and no ACTIVATE is issued. After a REFRESH, the next ACTIVATE waits exactly TRFC clocks when it is already requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_close | input | 1 | Close the row after this access (auto-precharge) |
| req_addr | input | 25 | Flat word address {row, bank, column} |
| cfg_cl | input | 3 | CAS latency in clocks (3 or 4) |
| cfg_al | input | 3 | Additive latency in clocks (0 to 4) |
| cfg_bl8 | input | 1 | Burst length 8 when 1, 4 when 0 |
| rd_lat | output | 4 | Read latency in clocks |
| wr_lat | output | 4 | Write latency in clocks |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_ba | output | 2 | Bank address |
| cmd_addr | output | 13 | Row/column address, bit 10 is the close/all flag |

## Verification
The hardest situation to reach from the ports is a refresh demand that arrives while several banks hold open rows. The refresh timer is free-running and cannot be steered. The stimulus therefore runs its request table inside one refresh window and deliberately leaves all four banks open. It then waits for the next demand and checks the precharge-all and refresh pair. The row-cycle race between a back-to-back auto-precharge and a re-activate of the same bank is reached by holding the second request valid directly behind the first. This is repeated under read, long-burst write and additive-latency settings, so that a different timer sets the gap each time.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  localparam int CNT_W = 6;

  typedef enum logic [2:0] {C_NOP, C_ACT, C_RD, C_WR, C_PRE, C_REF} dcmd_e;

  // {ras_n, cas_n, we_n} for each command
  function automatic logic [2:0] pin_code(dcmd_e c);
    case (c)
      C_ACT:   return 3'b011;
      C_RD:    return 3'b101;
      C_WR:    return 3'b100;
      C_PRE:   return 3'b010;
      C_REF:   return 3'b001;
      default: return 3'b111;
    endcase
  endfunction

  function automatic logic [3:0] rd_latency(logic [2:0] al, logic [2:0] cl);
    return {1'b0, al} + {1'b0, cl};
  endfunction

  function automatic logic [3:0] wr_latency(logic [2:0] al, logic [2:0] cl);
    return rd_latency(al, cl) - 4'd1;
  endfunction

  // clocks from a column command until its bank may be precharged
  function automatic logic [CNT_W-1:0] col_to_pre(logic wr, logic [2:0] al, logic [2:0] cl,
                                                  logic bl8, logic [3:0] twr);
    logic [CNT_W-1:0] half;
    half = bl8 ? CNT_W'(4) : CNT_W'(2);
    if (wr) return CNT_W'(wr_latency(al, cl)) + half + CNT_W'(twr);
    return CNT_W'(al) + half;
  endfunction

  // one clock of countdown, but never below a newly imposed wait
  function automatic logic [CNT_W-1:0] stretch(logic [CNT_W-1:0] cur, logic [CNT_W-1:0] need);
    logic [CNT_W-1:0] d;
    d = (cur == '0) ? '0 : cur - CNT_W'(1);
    return (d > need) ? d : need;
  endfunction
endpackage

// File: rtl/dcs_bank.sv
module dcs_bank
  import dcs_pkg::*;
#(
  parameter int ROW_W = 13,
  parameter int TRCD  = 3,
  parameter int TRP   = 3,
  parameter int TRC   = 11,
  parameter int TRFC  = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             do_act,
  input  logic             do_col,
  input  logic             col_close,
  input  logic [CNT_W-1:0] col_c2p,
  input  logic             do_pre,
  input  logic             do_ref,
  input  logic [ROW_W-1:0] act_row,
  output logic             is_open,
  output logic [ROW_W-1:0] open_row,
  output logic             col_ok,
  output logic             pre_ok,
  output logic             act_ok
);
  localparam logic [CNT_W-1:0] L_RCD = CNT_W'(TRCD - 1);
  localparam logic [CNT_W-1:0] L_RP  = CNT_W'(TRP - 1);
  localparam logic [CNT_W-1:0] L_RC  = CNT_W'(TRC - 1);
  localparam logic [CNT_W-1:0] L_RAS = CNT_W'(TRC - TRP - 1);
  localparam logic [CNT_W-1:0] L_RFC = CNT_W'(TRFC - 1);

  logic [CNT_W-1:0] col_w, pre_w, act_w;
  logic [CNT_W-1:0] n_col, n_pre, n_act;

  always_comb begin
    n_col = stretch(col_w, '0);
    n_pre = stretch(pre_w, '0);
    n_act = stretch(act_w, '0);
    if (do_act) begin
      n_col = L_RCD;
      n_pre = stretch(pre_w, L_RAS);
      n_act = stretch(act_w, L_RC);
    end
    if (do_col) begin
      n_pre = stretch(pre_w, col_c2p - CNT_W'(1));
      if (col_close) n_act = stretch(act_w, col_c2p + L_RP);
    end
    if (do_pre) n_act = stretch(act_w, L_RP);
    if (do_ref) n_act = stretch(act_w, L_RFC);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_w    <= '0;
      pre_w    <= '0;
      act_w    <= '0;
      is_open  <= 1'b0;
      open_row <= '0;
    end else begin
      col_w <= n_col;
      pre_w <= n_pre;
      act_w <= n_act;
      if (do_act) begin
        is_open  <= 1'b1;
        open_row <= act_row;
      end else if (do_pre || (do_col && col_close)) begin
        is_open <= 1'b0;
      end
    end
  end

  assign col_ok = (col_w == '0);
  assign pre_ok = (pre_w == '0);
  assign act_ok = (act_w == '0);

  p_act_closed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    do_act |-> (!is_open && act_ok));
  p_col_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    do_col |-> (is_open && col_ok));
  p_pre_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (do_pre && is_open) |-> pre_ok);
  p_ap_closes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (do_col && col_close) |=> !is_open);
  p_ref_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    do_ref |-> !is_open);
endmodule

// File: rtl/dcs_refresh.sv
module dcs_refresh #(
  parameter int PERIOD = 1560,
  localparam int W = $clog2(PERIOD + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_done,
  output logic pend,
  output logic tick
);
  logic [W-1:0] cnt;

  assign tick = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= W'(PERIOD - 1);
      pend <= 1'b0;
    end else begin
      cnt <= tick ? W'(PERIOD - 1) : cnt - W'(1);
      if (tick)          pend <= 1'b1;
      else if (ref_done) pend <= 1'b0;
    end
  end

  p_tick_raises_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> pend);
  p_done_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_done && !tick) |=> !pend);
endmodule

// File: rtl/dram_cmd_sched.sv
module dram_cmd_sched
  import dcs_pkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int BANK_W = 2,
  parameter int AP_BIT = 10,
  parameter int TRCD   = 3,
  parameter int TRP    = 3,
  parameter int TRC    = 11,
  parameter int TWR    = 3,
  parameter int TRFC   = 15,
  parameter int TREFI  = 1560,
  localparam int ADDR_W = ROW_W + BANK_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_close,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        cfg_cl,
  input  logic [2:0]        cfg_al,
  input  logic              cfg_bl8,
  output logic [3:0]        rd_lat,
  output logic [3:0]        wr_lat,
  output logic              cmd_cs_n,
  output logic              cmd_ras_n,
  output logic              cmd_cas_n,
  output logic              cmd_we_n,
  output logic [BANK_W-1:0] cmd_ba,
  output logic [ROW_W-1:0]  cmd_addr
);
  localparam int NBANK = 1 << BANK_W;

  // request fields
  logic [BANK_W-1:0] rq_bank;
  logic [ROW_W-1:0]  rq_row;
  logic [COL_W-1:0]  rq_col;
  assign rq_col  = req_addr[COL_W-1:0];
  assign rq_bank = req_addr[COL_W +: BANK_W];
  assign rq_row  = req_addr[COL_W + BANK_W +: ROW_W];

  // bank state, brought out as named wires
  logic [NBANK-1:0] b_open, b_col_ok, b_pre_ok, b_act_ok;
  logic [NBANK-1:0] sel_act, sel_col, sel_pre;
  logic [ROW_W-1:0] b_row [NBANK];
  logic [CNT_W-1:0] c2p;
  dcmd_e            nxt_cmd;
  logic             pre_all, issue_ref, ref_pend, ref_tick;
  logic             any_open, all_pre_ok, all_act_ok, row_hit;

  assign c2p = col_to_pre(req_write, cfg_al, cfg_cl, cfg_bl8, TWR[3:0]);
  assign rd_lat = rd_latency(cfg_al, cfg_cl);
  assign wr_lat = wr_latency(cfg_al, cfg_cl);

  for (genvar i = 0; i < NBANK; i++) begin : g_bank
    assign sel_act[i] = (nxt_cmd == C_ACT) && (rq_bank == BANK_W'(i));
    assign sel_col[i] = ((nxt_cmd == C_RD) || (nxt_cmd == C_WR)) && (rq_bank == BANK_W'(i));
    assign sel_pre[i] = (nxt_cmd == C_PRE) && (pre_all || (rq_bank == BANK_W'(i)));
    dcs_bank #(.ROW_W(ROW_W), .TRCD(TRCD), .TRP(TRP), .TRC(TRC), .TRFC(TRFC)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .do_act   (sel_act[i]),
      .do_col   (sel_col[i]),
      .col_close(req_close),
      .col_c2p  (c2p),
      .do_pre   (sel_pre[i]),
      .do_ref   (issue_ref),
      .act_row  (rq_row),
      .is_open  (b_open[i]),
      .open_row (b_row[i]),
      .col_ok   (b_col_ok[i]),
      .pre_ok   (b_pre_ok[i]),
      .act_ok   (b_act_ok[i])
    );
  end

  dcs_refresh #(.PERIOD(TREFI)) u_refresh (
    .clk     (clk),
    .rst_n   (rst_n),
    .ref_done(issue_ref),
    .pend    (ref_pend),
    .tick    (ref_tick)
  );

  assign any_open   = |b_open;
  assign all_pre_ok = &(b_pre_ok | ~b_open);
  assign all_act_ok = &b_act_ok;
  assign row_hit    = b_open[rq_bank] && (b_row[rq_bank] == rq_row);
  assign issue_ref  = (nxt_cmd == C_REF);
  assign req_ready  = (nxt_cmd == C_RD) || (nxt_cmd == C_WR);

  // command choice: refresh first, then the pending request
  always_comb begin
    nxt_cmd = C_NOP;
    pre_all = 1'b0;
    if (ref_pend) begin
      if (any_open) begin
        pre_all = 1'b1;
        if (all_pre_ok) nxt_cmd = C_PRE;
      end else if (all_act_ok) begin
        nxt_cmd = C_REF;
      end
    end else if (req_valid) begin
      if (row_hit) begin
        if (b_col_ok[rq_bank]) nxt_cmd = req_write ? C_WR : C_RD;
      end else if (b_open[rq_bank]) begin
        if (b_pre_ok[rq_bank]) nxt_cmd = C_PRE;
      end else if (b_act_ok[rq_bank]) begin
        nxt_cmd = C_ACT;
      end
    end
  end

  logic [ROW_W-1:0]  nxt_addr;
  logic [BANK_W-1:0] nxt_ba;
  always_comb begin
    nxt_addr = '0;
    nxt_ba   = rq_bank;
    case (nxt_cmd)
      C_ACT: nxt_addr = rq_row;
      C_RD, C_WR: begin
        nxt_addr[COL_W-1:0] = rq_col;
        nxt_addr[AP_BIT]    = req_close;
      end
      C_PRE: nxt_addr[AP_BIT] = pre_all;
      default: nxt_ba = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_cs_n <= 1'b0;
      {cmd_ras_n, cmd_cas_n, cmd_we_n} <= 3'b111;
      cmd_ba   <= '0;
      cmd_addr <= '0;
    end else begin
      cmd_cs_n <= 1'b0;
      {cmd_ras_n, cmd_cas_n, cmd_we_n} <= pin_code(nxt_cmd);
      cmd_ba   <= nxt_ba;
      cmd_addr <= nxt_addr;
    end
  end

  p_cs_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_cs_n == 1'b0);
  p_ready_col_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (cmd_ras_n && !cmd_cas_n));
  p_lat_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lat + 4'd1) == rd_lat);
  p_ref_priority_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pend |-> (!req_ready && (nxt_cmd != C_ACT)));
  p_ref_closed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    issue_ref |-> !any_open);
endmodule

// File: tb/test_dram_cmd_sched.sv
module test_dram_cmd_sched;
  localparam int REFI = 600;
  localparam int TRCD = 3, TRP = 3, TRC = 11, TWR = 3, TRFC = 15;
  localparam logic [2:0] K_NOP = 0, K_ACT = 1, K_RD = 2, K_WR = 3, K_PRE = 4, K_REF = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_close = 1'b0;
  logic [24:0] req_addr = '0;
  logic [2:0] cfg_cl = 3'd3, cfg_al = 3'd0;
  logic cfg_bl8 = 1'b0;
  logic req_ready, cs_n, ras_n, cas_n, we_n;
  logic [3:0] rd_lat, wr_lat;
  logic [1:0] ba;
  logic [12:0] addr;

  always #10 clk = ~clk;

  dram_cmd_sched #(.TREFI(REFI)) i_dram_cmd_sched (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_close(req_close), .req_addr(req_addr),
    .cfg_cl(cfg_cl), .cfg_al(cfg_al), .cfg_bl8(cfg_bl8),
    .rd_lat(rd_lat), .wr_lat(wr_lat), .cmd_cs_n(cs_n), .cmd_ras_n(ras_n),
    .cmd_cas_n(cas_n), .cmd_we_n(we_n), .cmd_ba(ba), .cmd_addr(addr));

  int n_chk = 0, n_fail = 0, cyc = 0, n_log = 0;
  bit done = 0;
  int lg_t [1024];
  logic [2:0] lg_k [1024];
  logic [1:0] lg_ba [1024];
  logic [12:0] lg_a [1024];

  function automatic logic [2:0] kind_of(logic r, logic c, logic w);
    case ({r, c, w})
      3'b011: return K_ACT;
      3'b101: return K_RD;
      3'b100: return K_WR;
      3'b010: return K_PRE;
      3'b001: return K_REF;
      default: return K_NOP;
    endcase
  endfunction

  function automatic int exp_c2p(bit wr, int al, int cl, bit bl8);
    int half = bl8 ? 4 : 2;
    return wr ? (al + cl - 1) + half + TWR : al + half;
  endfunction

  always @(posedge clk) cyc = cyc + 1;

  always @(negedge clk)
    if (rst_n && kind_of(ras_n, cas_n, we_n) != K_NOP && n_log < 1024) begin
      lg_t[n_log] = cyc; lg_k[n_log] = kind_of(ras_n, cas_n, we_n);
      lg_ba[n_log] = ba; lg_a[n_log] = addr;
      n_log = n_log + 1;
    end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_req(bit wr, bit cl, logic [1:0] bk, logic [12:0] row, logic [9:0] col,
                        output int hs);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_close = cl; req_addr = {row, bk, col};
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    hs = cyc;
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic wait_ref(output int idx);
    int start = n_log;
    forever begin
      @(negedge clk); #2;
      if (n_log > start && lg_k[n_log-1] == K_REF) break;
    end
    idx = n_log - 1;
  endtask

  typedef struct packed {
    logic wr; logic cl; logic [1:0] bk; logic [12:0] row; logic [9:0] col;
    logic [1:0] n; logic [2:0] k0; logic [2:0] k1; logic [2:0] k2;
  } vec_t;

  // request, then the expected command kinds in order
  localparam vec_t VT [9] = '{
    '{1'b0, 1'b0, 2'd0, 13'd5,    10'd8,    2'd2, K_ACT, K_RD,  K_NOP},
    '{1'b0, 1'b0, 2'd0, 13'd5,    10'd16,   2'd1, K_RD,  K_NOP, K_NOP},
    '{1'b1, 1'b0, 2'd0, 13'd9,    10'd0,    2'd3, K_PRE, K_ACT, K_WR },
    '{1'b1, 1'b1, 2'd1, 13'd2,    10'd4,    2'd2, K_ACT, K_WR,  K_NOP},
    '{1'b0, 1'b0, 2'd1, 13'd2,    10'd4,    2'd2, K_ACT, K_RD,  K_NOP},
    '{1'b0, 1'b1, 2'd0, 13'd9,    10'd12,   2'd1, K_RD,  K_NOP, K_NOP},
    '{1'b0, 1'b0, 2'd0, 13'd9,    10'd3,    2'd2, K_ACT, K_RD,  K_NOP},
    '{1'b1, 1'b0, 2'd3, 13'h1FFF, 10'h3FF,  2'd2, K_ACT, K_WR,  K_NOP},
    '{1'b0, 1'b0, 2'd2, 13'd0,    10'd0,    2'd2, K_ACT, K_RD,  K_NOP}
  };

  task automatic run_rc(bit wr, int al, bit bl8);
    int hs, st, gap;
    cfg_al = 3'(al); cfg_bl8 = bl8;
    st = n_log;
    do_req(wr, 1'b1, 2'd2, 13'd7, 10'd2, hs);
    do_req(1'b0, 1'b1, 2'd2, 13'd7, 10'd2, hs);
    idle(30);
    chk(n_log - st == 4, "R6", "commands in row-cycle test", n_log - st, 4);
    chk(lg_k[st] == K_ACT && lg_k[st+2] == K_ACT, "R6", "reactivate kinds",
        int'(lg_k[st+2]), int'(K_ACT));
    chk(lg_k[st+1] == (wr ? K_WR : K_RD) && lg_a[st+1][10], "R6", "auto-precharge column",
        int'(lg_a[st+1][10]), 1);
    gap = TRCD + exp_c2p(wr, al, 3, bl8) + TRP;
    if (gap < TRC) gap = TRC;
    chk(lg_t[st+2] - lg_t[st] == gap, "R7", "ACT to ACT after auto-precharge",
        lg_t[st+2] - lg_t[st], gap);
    cfg_al = 3'd0; cfg_bl8 = 1'b0;
    idle(30);
  endtask

  initial begin
    int hs, st, ir, i1, i2;
    logic [2:0] ek [3];
    repeat (5) @(negedge clk);
    // reset state (R2)
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R2", "bus during reset",
        int'({cs_n, ras_n, cas_n, we_n}), 7);
    rst_n = 1;
    idle(3);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0111 && !req_ready, "R2", "idle bus after reset",
        int'({cs_n, ras_n, cas_n, we_n}), 7);

    // latencies (R8)
    for (int c = 3; c <= 4; c++)
      for (int a = 0; a <= 4; a++) begin
        @(negedge clk); cfg_cl = 3'(c); cfg_al = 3'(a); #1;
        chk(int'(rd_lat) == a + c, "R8", "read latency", int'(rd_lat), a + c);
        chk(int'(wr_lat) == a + c - 1, "R8", "write latency", int'(wr_lat), a + c - 1);
      end
    cfg_cl = 3'd3; cfg_al = 3'd0;

    // vector table inside one refresh window
    wait_ref(ir);
    idle(20);
    for (int v = 0; v < 9; v++) begin
      st = n_log;
      do_req(VT[v].wr, VT[v].cl, VT[v].bk, VT[v].row, VT[v].col, hs);
      idle(20);
      ek[0] = VT[v].k0; ek[1] = VT[v].k1; ek[2] = VT[v].k2;
      chk(n_log - st == int'(VT[v].n), "R4", "command count", n_log - st, int'(VT[v].n));
      for (int j = 0; j < int'(VT[v].n); j++) begin
        chk(lg_k[st+j] == ek[j], "R4", "command kind", int'(lg_k[st+j]), int'(ek[j]));
        chk(lg_ba[st+j] == VT[v].bk, "R1", "bank field", int'(lg_ba[st+j]), int'(VT[v].bk));
        if (lg_k[st+j] == K_ACT)
          chk(lg_a[st+j] == VT[v].row, "R1", "row field", int'(lg_a[st+j]), int'(VT[v].row));
        if (lg_k[st+j] == K_PRE)
          chk(!lg_a[st+j][10], "R4", "single-bank precharge flag", int'(lg_a[st+j][10]), 0);
        if (lg_k[st+j] == K_RD || lg_k[st+j] == K_WR)
          chk(lg_a[st+j] == {2'b00, VT[v].cl, VT[v].col}, "R1", "column field",
              int'(lg_a[st+j]), int'({2'b00, VT[v].cl, VT[v].col}));
        if (j > 0 && lg_k[st+j-1] == K_PRE)
          chk(lg_t[st+j] - lg_t[st+j-1] == TRP, "R5", "PRE to ACT", lg_t[st+j] - lg_t[st+j-1], TRP);
        if (j > 0 && lg_k[st+j-1] == K_ACT)
          chk(lg_t[st+j] - lg_t[st+j-1] == TRCD, "R5", "ACT to column", lg_t[st+j] - lg_t[st+j-1], TRCD);
      end
      chk(lg_t[n_log-1] == hs + 1, "R3", "column one clock after acceptance", lg_t[n_log-1], hs + 1);
    end

    // refresh with all banks open (R9)
    wait_ref(ir);
    chk(lg_k[ir-1] == K_PRE && lg_a[ir-1][10], "R9", "precharge-all before refresh",
        int'(lg_k[ir-1]), int'(K_PRE));
    chk(lg_t[ir] - lg_t[ir-1] == TRP, "R9", "PRE-all to REF", lg_t[ir] - lg_t[ir-1], TRP);
    wait_ref(i1);
    wait_ref(i2);
    chk(lg_t[i2] - lg_t[i1] == REFI, "R9", "refresh interval", lg_t[i2] - lg_t[i1], REFI);

    // activate right behind a refresh (R10)
    do_req(1'b0, 1'b0, 2'd3, 13'd100, 10'd5, hs);
    idle(10);
    chk(lg_k[i2+1] == K_ACT && lg_t[i2+1] - lg_t[i2] == TRFC, "R10", "REF to ACT",
        lg_t[i2+1] - lg_t[i2], TRFC);

    // row cycle against auto-precharge (R6, R7)
    run_rc(1'b0, 0, 1'b0);
    run_rc(1'b1, 0, 1'b1);
    run_rc(1'b0, 2, 1'b1);
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end
endmodule